// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer that software drives through four 16-bit registers. Software writes a timeout in half-second units and sets a run bit. After that it must keep the counter alive. Each service is two writes to the service register, a fixed first key followed by a fixed second key. When the counter runs out, the block raises a reset. Depending on a control bit, that reset goes to the external reset pin or to the internal reset request. A pre-timeout interrupt can be set to fire a chosen number of half-seconds before expiry, or at the moment of expiry itself.

A second, fixed-length watchdog is already counting when reset is released. Firmware stops it by clearing a bit. The block is clocked from a slow clock. A parameterised prescaler divides that clock down to a tick every half second, and both counters advance on that tick. Reads are combinational from the register address. Writes take effect on the next clock edge.

Top module: `kwdt_top`

## Requirements
- R1: After a synchronous reset, CTRL reads 0x0000, INTCTL reads 0x0000 and MISC reads 0x0001. All three outputs are low.
- R2: CTRL bits 15:8 hold a timeout field F, written as 2T−1 for T seconds. Setting CTRL bit 0 loads the counter with F+1. The counter then loses one count per tick, where a tick is TICK_DIV clocks from a free-running prescaler. The counter expires when it reaches zero.
- R3: CTRL bit 0 (run) is write-once. Once it is 1, writing 0 to it leaves it at 1 until reset.
- R4: The service register is at address 1 and always reads 0. Writing 0x5555 and then 0xAAAA reloads a running counter with F+1. A 0xAAAA without a preceding 0x5555 does not reload the counter. Any other value between the two keys also prevents the reload, and the key checker returns to idle.
- R5: Changing F while the counter runs does not alter the current count. The new value is used at the next reload.
- R6: On expiry, if CTRL bit 1 is 1 the block asserts ext_rst_o, and if it is 0 the block asserts rst_req_o. Either output stays high until reset.
- R7: INTCTL bit 15 enables the interrupt and bits 7:0 hold a count C. When the interrupt is enabled and the counter steps to C, status bit 14 sets. With C=0 this is the same edge as expiry. irq_o follows bit 14. Writing 1 to bit 14 clears it.
- R8: MISC bit 0 is the power-down enable and is 1 from reset. While it is 1, a second counter of PD_TICKS ticks runs, and when it expires it asserts rst_req_o. Writing 0 to the bit clears it and stops that counter. Writing 1 does not set it again.
- R9: The register addresses are 0 for CTRL, 1 for service, 2 for INTCTL and 3 for MISC. CTRL reads {F, 6'b0, bit1, run}. INTCTL reads {enable, status, 6'b0, C}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr |
| ext_rst_o | output | 1 | External reset pin, sticky |
| rst_req_o | output | 1 | Internal reset request, sticky |
| irq_o | output | 1 | Pre-timeout interrupt |

## Verification
A counter that holds a wrong value shows up only later, as a reset that rises one or more ticks too early or too late. For that reason the three outputs are compared with a behavioural model on every clock, so any error appears at the edge where it first has an effect. A key checker left in the wrong state shows up as a reload that should not have happened, or one that was missed, and the difference appears at the expiry edge. Sticky bits that are lost, or set again, show up at once in the register reads.

// File: rtl/kwdt_pkg.sv
// Shared constants for the keyed watchdog: register addresses and service keys.
package kwdt_pkg;
    localparam logic [1:0]  A_CTRL = 2'd0;
    localparam logic [1:0]  A_SVC  = 2'd1;
    localparam logic [1:0]  A_INT  = 2'd2;
    localparam logic [1:0]  A_MISC = 2'd3;
    localparam logic [15:0] KEY_A  = 16'h5555;
    localparam logic [15:0] KEY_B  = 16'hAAAA;
    typedef enum logic { KC_IDLE, KC_ARMED } kc_state_e;
endpackage

// File: rtl/kwdt_tick.sv
// Free-running prescaler that emits a one-clock tick every DIV clocks.
// Assumes DIV >= 2.
module kwdt_tick #(
    parameter int DIV = 16384
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = $clog2(DIV);
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] ps_q;

    assign tick = (ps_q == LAST);

    // Count clocks, wrapping to zero on the tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    ps_q <= '0;
        else if (tick) ps_q <= '0;
        else           ps_q <= ps_q + 1'b1;
    end
endmodule

// File: rtl/kwdt_keys.sv
// Service key checker. A second key that follows a first key produces a
// grant pulse. Any other write drops the checker back to idle.
// Assumes svc_wr is a one-clock strobe for a write to the service register.
module kwdt_keys
    import kwdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        svc_wr,
    input  logic [15:0] data,
    output logic        grant
);
    kc_state_e st_q;

    assign grant = svc_wr && (data == KEY_B) && (st_q == KC_ARMED);

    // Arm on the first key. Any other write returns to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)      st_q <= KC_IDLE;
        else if (svc_wr) st_q <= (data == KEY_A) ? KC_ARMED : KC_IDLE;
    end

    assert_key_disarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_wr && data != KEY_A) |=> (st_q == KC_IDLE));
endmodule

// File: rtl/kwdt_count.sv
// Main timeout down-counter in half-second ticks. load sets it to
// load_val+1. It then counts down while en is set, stops at zero and
// flags the pre-timeout hit and the expiry.
// Assumes load is only asserted together with or after en.
module kwdt_count #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          en,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    input  logic [TW-1:0] pre,
    output logic          expire,
    output logic          pre_hit
);
    localparam int CW = TW + 1;

    logic [CW-1:0] cnt_q;
    logic          dec;

    assign dec     = en && tick && (cnt_q != '0) && !load;
    assign expire  = dec && (cnt_q == CW'(1));
    assign pre_hit = dec && ((cnt_q - 1'b1) == {1'b0, pre});

    // Reload has priority over the tick decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (load) cnt_q <= {1'b0, load_val} + 1'b1;
        else if (dec)  cnt_q <= cnt_q - 1'b1;
    end

    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (cnt_q == '0));
endmodule

// File: rtl/kwdt_pdog.sv
// Power-down watchdog: a fixed count of ticks that starts from reset and
// pulses expire when it runs out, unless run has been cleared first.
module kwdt_pdog #(
    parameter int PD_TICKS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    output logic expire
);
    localparam int LW = $clog2(PD_TICKS + 1);

    logic [LW-1:0] left_q;

    assign expire = run && tick && (left_q == LW'(1));

    // Count down on each tick while running, and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                            left_q <= LW'(PD_TICKS);
        else if (run && tick && left_q != '0) left_q <= left_q - 1'b1;
    end

    assert_pd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(left_q));
endmodule

// File: rtl/kwdt_top.sv
// Keyed-service watchdog. Holds the register file, the sticky run,
// reset and interrupt bits, and connects the prescaler, the key checker,
// the main counter and the power-down counter.
// Assumes clk is the slow clock, and that TICK_DIV clocks make half a second.
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int TICK_DIV = 16384,
    parameter int PD_TICKS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        ext_rst_o,
    output logic        rst_req_o,
    output logic        irq_o
);
    localparam int TW = 8;

    logic          en_q, ext_sel_q, ien_q, ist_q, pd_en_q, ext_q, req_q;
    logic [TW-1:0] wt_q, icnt_q;
    logic          ctrl_we, svc_we, int_we, misc_we;
    logic          tick, grant, load, wd_exp, pre_hit, pd_exp;
    logic [TW-1:0] load_val;

    assign ctrl_we = wr_en && (addr == A_CTRL);
    assign svc_we  = wr_en && (addr == A_SVC);
    assign int_we  = wr_en && (addr == A_INT);
    assign misc_we = wr_en && (addr == A_MISC);

    assign load     = (ctrl_we && !en_q && wdata[0]) || (grant && en_q);
    assign load_val = ctrl_we ? wdata[15:8] : wt_q;

    kwdt_tick #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

    kwdt_keys u_keys (.clk(clk), .rst_n(rst_n), .svc_wr(svc_we),
                      .data(wdata), .grant(grant));

    kwdt_count #(.TW(TW)) u_count (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(en_q), .load(load),
        .load_val(load_val), .pre(icnt_q), .expire(wd_exp), .pre_hit(pre_hit));

    kwdt_pdog #(.PD_TICKS(PD_TICKS)) u_pdog (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(pd_en_q), .expire(pd_exp));

    // Control register: the run bit can only be set, the other fields are plain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0; ext_sel_q <= 1'b0; wt_q <= '0;
        end else if (ctrl_we) begin
            en_q      <= en_q | wdata[0];
            ext_sel_q <= wdata[1];
            wt_q      <= wdata[15:8];
        end
    end

    // Interrupt control: the status bit is set by the pre-timeout hit and
    // cleared by writing 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= 1'b0; ist_q <= 1'b0; icnt_q <= '0;
        end else begin
            if (int_we) begin
                ien_q  <= wdata[15];
                icnt_q <= wdata[7:0];
            end
            if (pre_hit && ien_q)          ist_q <= 1'b1;
            else if (int_we && wdata[14])  ist_q <= 1'b0;
        end
    end

    // Power-down enable: software can clear it but cannot set it again.
    always_ff @(posedge clk) begin
        if (!rst_n)                    pd_en_q <= 1'b1;
        else if (misc_we && !wdata[0]) pd_en_q <= 1'b0;
    end

    // Sticky reset outputs, sent according to the routing bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q <= 1'b0; req_q <= 1'b0;
        end else begin
            if (wd_exp && ext_sel_q)              ext_q <= 1'b1;
            if ((wd_exp && !ext_sel_q) || pd_exp) req_q <= 1'b1;
        end
    end

    // Combinational read mux.
    always_comb begin
        unique case (addr)
            A_CTRL:  rdata = {wt_q, 6'b0, ext_sel_q, en_q};
            A_INT:   rdata = {ien_q, ist_q, 6'b0, icnt_q};
            A_MISC:  rdata = {15'b0, pd_en_q};
            default: rdata = 16'h0000;
        endcase
    end

    assign ext_rst_o = ext_q;
    assign rst_req_o = req_q;
    assign irq_o     = ist_q;

    assert_run_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> en_q);
    assert_ext_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rst_o |=> ext_rst_o);
    assert_req_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> rst_req_o);
    assert_pd_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_en_q |=> !pd_en_q);
    assert_irq_at_expiry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_exp && ien_q && icnt_q == '0) |=> irq_o);
endmodule

// File: tb/test_kwdt_top.sv
// Bench for kwdt_top. A behavioural model is updated on every rising edge
// and the three outputs are compared with it on every falling edge.
module test_kwdt_top;
    localparam int DIV = 4;
    localparam int PDT = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        ext_rst_o, rst_req_o, irq_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    kwdt_top #(.TICK_DIV(DIV), .PD_TICKS(PDT)) i_kwdt_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ext_rst_o(ext_rst_o), .rst_req_o(rst_req_o), .irq_o(irq_o));

    // Model state.
    int m_ps, m_cnt, m_pdl, m_wt, m_ic, lv;
    bit m_en, m_ext, m_ien, m_ist, m_pd, m_orst, m_req, m_arm;
    bit tk, ld, o_en, o_ext, o_pd, o_ien;
    int o_ic;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ps = 0; m_cnt = 0; m_pdl = PDT; m_wt = 0; m_ic = 0;
            m_en = 0; m_ext = 0; m_ien = 0; m_ist = 0; m_pd = 1;
            m_orst = 0; m_req = 0; m_arm = 0;
        end else begin
            tk = (m_ps == DIV - 1); ld = 0; lv = m_wt;
            o_en = m_en; o_ext = m_ext; o_pd = m_pd; o_ien = m_ien; o_ic = m_ic;
            if (wr_en) begin
                case (addr)
                    2'd0: begin
                        if (!m_en && wdata[0]) begin ld = 1; lv = int'(wdata[15:8]); end
                        m_en = m_en | wdata[0]; m_ext = wdata[1]; m_wt = int'(wdata[15:8]);
                    end
                    2'd1: begin
                        if (wdata == 16'h5555) m_arm = 1;
                        else begin
                            if (wdata == 16'hAAAA && m_arm && o_en) ld = 1;
                            m_arm = 0;
                        end
                    end
                    2'd2: begin
                        m_ien = wdata[15]; m_ic = int'(wdata[7:0]);
                        if (wdata[14]) m_ist = 0;
                    end
                    default: if (!wdata[0]) m_pd = 0;
                endcase
            end
            if (ld) m_cnt = lv + 1;
            else if (o_en && tk && m_cnt != 0) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin
                    if (o_ext) m_orst = 1; else m_req = 1;
                end
                if (o_ien && m_cnt == o_ic) m_ist = 1;
            end
            if (o_pd && tk && m_pdl != 0) begin
                m_pdl = m_pdl - 1;
                if (m_pdl == 0) m_req = 1;
            end
            m_ps = tk ? 0 : m_ps + 1;
        end
    end

    // Per-cycle comparison of the outputs (R2 R4 R5 R6 R7 R8).
    always @(negedge clk) begin
        if (rst_n) begin
            n_cmp++;
            if (ext_rst_o !== m_orst || rst_req_o !== m_req || irq_o !== m_ist) begin
                n_bad++;
                $display("FAIL R2/R4/R6/R7/R8 outputs t=%0t actual ext=%b req=%b irq=%b expected ext=%b req=%b irq=%b",
                         $time, ext_rst_o, rst_req_o, irq_o, m_orst, m_req, m_ist);
            end
        end
    end

    function automatic logic [15:0] exp_reg(input logic [1:0] a);
        case (a)
            2'd0:    return {m_wt[7:0], 6'b0, m_ext, m_en};
            2'd2:    return {m_ien, m_ist, 6'b0, m_ic[7:0]};
            2'd3:    return {15'b0, m_pd};
            default: return 16'h0;
        endcase
    endfunction

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, input string tag);
        @(negedge clk);
        addr = a;
        #1 chk(rdata, exp_reg(a), tag);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        // Watchdog for a hung run.
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 R9 reset values and address map.
        rd(2'd0, "R1 ctrl reset"); chk(16'(rdata), 16'h0000, "R1 ctrl value");
        rd(2'd1, "R9 service reads zero");
        rd(2'd2, "R1 intctl reset"); chk(rdata, 16'h0000, "R1 intctl value");
        rd(2'd3, "R1 misc reset");   chk(rdata, 16'h0001, "R1 misc value");
        chk({13'b0, ext_rst_o, rst_req_o, irq_o}, 16'h0, "R1 outputs low");
        // R8 power-down watchdog expires when left alone.
        idle(PDT * DIV + 8);
        @(negedge clk); chk({15'b0, rst_req_o}, 16'h1, "R8 pd expiry");

        // R8 clear, no re-set; R6 R7 external route with C=0.
        do_reset();
        wr(2'd3, 16'h0000); wr(2'd3, 16'h0001);
        rd(2'd3, "R8 pd stays clear"); chk(rdata, 16'h0000, "R8 misc value");
        idle(PDT * DIV + 8);
        @(negedge clk); chk({15'b0, rst_req_o}, 16'h0, "R8 pd stopped");
        wr(2'd2, 16'h8000);
        wr(2'd0, 16'h0303);
        wr(2'd0, 16'h0302);
        rd(2'd0, "R3 run sticky"); chk({15'b0, rdata[0]}, 16'h1, "R3 run bit");
        idle(5 * DIV + 4);
        @(negedge clk);
        chk({14'b0, ext_rst_o, irq_o}, 16'h3, "R6 R7 ext and irq together");
        chk({15'b0, rst_req_o}, 16'h0, "R6 internal not routed");

        // R4 good service keeps it alive, bad sequences do not.
        do_reset();
        wr(2'd3, 16'h0000);
        wr(2'd0, 16'h0F01);
        for (int i = 0; i < 6; i++) begin
            idle(20); wr(2'd1, 16'h5555); wr(2'd1, 16'hAAAA);
        end
        @(negedge clk); chk({15'b0, rst_req_o}, 16'h0, "R4 serviced no expiry");
        for (int i = 0; i < 6; i++) begin
            idle(20); wr(2'd1, 16'hAAAA);
            wr(2'd1, 16'h5555); wr(2'd1, 16'h1234); wr(2'd1, 16'hAAAA);
        end
        @(negedge clk); chk({15'b0, rst_req_o}, 16'h1, "R4 R6 bad keys expire");

        // R5 timeout rewrite applies at next reload; R7 pre-timeout.
        do_reset();
        wr(2'd3, 16'h0000);
        wr(2'd2, 16'h8001);
        wr(2'd0, 16'h0F01);
        idle(10);
        wr(2'd0, 16'h0101);
        idle(30);
        @(negedge clk); chk({15'b0, rst_req_o}, 16'h0, "R5 old count still running");
        wr(2'd1, 16'h5555); wr(2'd1, 16'hAAAA);
        idle(3 * DIV + 4);
        @(negedge clk); chk({14'b0, rst_req_o, irq_o}, 16'h3, "R5 R7 short timeout used");

        // R7 W1C of status before expiry.
        do_reset();
        wr(2'd3, 16'h0000);
        wr(2'd2, 16'h8005);
        wr(2'd0, 16'h0F01);
        for (int i = 0; i < 200 && !irq_o; i++) idle(1);
        @(negedge clk); chk({15'b0, irq_o}, 16'h1, "R7 pre-timeout raised");
        wr(2'd2, 16'hC005);
        @(negedge clk); chk({15'b0, irq_o}, 16'h0, "R7 W1C cleared");
        rd(2'd2, "R7 intctl readback");
        idle(40);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule